// File: doc/BRIEF.md
# Capture-Mode Timer Channel

This block is one channel of a general-purpose timer, built for event timing. A free-running up-counter advances on each cycle in which the counting-clock enable is high. Edges on input A copy the current count into two capture registers, RA and RB. RA and RB are always filled as an ordered pair: RA first, then RB. This lets software measure a pulse width or a period from one pair of timestamps.

The counter is restarted (forced to zero) by any of three things:
- a selected edge on input A or input B;
- a software trigger command;
- optionally, a match against a compare value RC.

After RB is captured, the counter can either halt until the next restart, or have its counting clock switched off until software enables it again.

Events are kept in sticky status bits that clear on a status read:
- counter wrap;
- capture overrun;
- RC match;
- RA loaded;
- RB loaded;
- external trigger.

Both pins are inputs only. They are resynchronised into the system clock domain before edges are detected.

Top module: `cap_timer_chan`

## Requirements
- R1: After synchronous reset, cnt, ra, rb and status are all zero, and the counting clock is disabled: ticks leave cnt at 0 until cmd_en is pulsed.
- R2: While the clock is enabled and not halted, every cycle with cnt_tick high adds one to cnt. A tick at 2^CNT_W-1 wraps cnt to 0 and sets status bit 0.
- R3: Mode bits [1:0] select the input A edge that loads RA: 0 none, 1 rising, 2 falling, 3 both. A load is allowed only when no RA value is waiting for its RB. It stores the cnt value of the cycle in which the synchronised edge is detected, and sets status bit 5.
- R4: Mode bits [3:2] select the input A edge that loads RB, with the same encoding. RB loads only after an RA load that has no RB yet, and the load sets status bit 6.
- R5: Loading RA or RB while its previous value is still unread sets status bit 1. A pulse on rd_ra or rd_rb marks that register as read.
- R6: Mode bits [5:4] select the external trigger edge (same encoding). Mode bit 6 picks input A (1) or input B (0) as the trigger source. A trigger sets cnt to 0 and sets status bit 7. An edge on the unselected pin has no effect. A capture in the same cycle stores the count from before the reset.
- R7: A tick with cnt equal to the RC value sets status bit 4. If mode bit 7 is set, that tick sets cnt to 0 instead of incrementing it.
- R8: If mode bit 8 is set, an RB load halts the counter. It stays halted until the next trigger, which restarts it from 0.
- R9: If mode bit 9 is set, an RB load disables the counting clock. A later trigger zeroes cnt but does not resume counting; only cmd_en resumes it.
- R10: Status bits are sticky, and bits 2 and 3 read 0. A rd_stat pulse clears all bits, but an event in the same cycle is kept.
- R11: cmd_dis wins over cmd_en in the same cycle. cmd_trg zeroes cnt without setting status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Counting-clock enable |
| pin_a | input | 1 | Asynchronous input A (capture and trigger source) |
| pin_b | input | 1 | Asynchronous input B (trigger source) |
| cfg_wr | input | 1 | Write cfg_mode and cfg_rc |
| cfg_mode | input | 10 | Mode word |
| cfg_rc | input | CNT_W | Compare value RC |
| cmd_en | input | 1 | Enable counting clock |
| cmd_dis | input | 1 | Disable counting clock |
| cmd_trg | input | 1 | Software trigger |
| rd_stat | input | 1 | Status read (clears sticky bits) |
| rd_ra | input | 1 | RA read strobe |
| rd_rb | input | 1 | RB read strobe |
| ra | output | CNT_W | Capture register A |
| rb | output | CNT_W | Capture register B |
| cnt | output | CNT_W | Counter value |
| status | output | 8 | Sticky status flags |

## Verification
The main collision is an input A edge that is both a capture edge and a trigger edge in the same cycle. The bench selects the rising edge of A for both the RA load and the trigger, with the counter held at a known value. It then expects RA to hold the pre-reset count while cnt reads 0 and status bits 5 and 7 are both set.

A second collision is a status read that lands on the same cycle as a fresh RA load. The bench places rd_stat exactly two cycles after the pin change, which is the detection cycle. The result is judged by the old trigger bit being gone while bit 5 survives.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int MODE_W = 10;
  localparam int STAT_W = 8;

  localparam int ST_OVF  = 0;
  localparam int ST_LOVR = 1;
  localparam int ST_RC   = 4;
  localparam int ST_LDA  = 5;
  localparam int ST_LDB  = 6;
  localparam int ST_TRG  = 7;

  typedef enum logic [1:0] {
    EDG_NONE = 2'd0,
    EDG_RISE = 2'd1,
    EDG_FALL = 2'd2,
    EDG_BOTH = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic      dis_on_b;
    logic      stop_on_b;
    logic      rc_trg;
    logic      trg_from_a;
    edge_sel_e trg_edge;
    edge_sel_e ldb_edge;
    edge_sel_e lda_edge;
  } mode_t;

  function automatic logic edge_match(edge_sel_e sel, logic rise, logic fall);
    logic hit;
    case (sel)
      EDG_RISE: hit = rise;
      EDG_FALL: hit = fall;
      EDG_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh;
  logic            level;
  logic            prev;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SH_W-2:0], pin};
  end

  assign level = sh[SYNC_STAGES-1];
  assign prev  = sh[SYNC_STAGES];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cmd_en,
  input  logic             cmd_dis,
  input  logic             ext_restart,
  input  logic             halt_req,
  input  logic             dis_req,
  input  logic             rc_trg_en,
  input  logic [CNT_W-1:0] rc_val,
  output logic [CNT_W-1:0] cnt,
  output logic             clk_en,
  output logic             run,
  output logic             rc_hit,
  output logic             ovf_hit
);
  logic stopped;
  logic step;
  logic do_rst;

  assign run     = clk_en & ~stopped;
  assign step    = run & tick;
  assign rc_hit  = step & (cnt == rc_val);
  assign do_rst  = ext_restart | (rc_hit & rc_trg_en);
  assign ovf_hit = step & (cnt == '1) & ~do_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      clk_en  <= 1'b0;
      stopped <= 1'b0;
    end else begin
      if (cmd_dis || dis_req) clk_en <= 1'b0;
      else if (cmd_en)        clk_en <= 1'b1;

      if (halt_req)    stopped <= 1'b1;
      else if (do_rst) stopped <= 1'b0;

      if (do_rst)    cnt <= '0;
      else if (step) cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cap_regs.sv
module cap_regs
  import cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              lda_hit,
  input  logic              ldb_hit,
  input  logic              rd_ra,
  input  logic              rd_rb,
  input  logic              rd_stat,
  input  logic              ovf_hit,
  input  logic              rc_hit,
  input  logic              trg_hit,
  output logic [CNT_W-1:0]  ra,
  output logic [CNT_W-1:0]  rb,
  output logic [STAT_W-1:0] status,
  output logic              pair_open,
  output logic              ldb_go
);
  logic              lda_go;
  logic              ra_full;
  logic              rb_full;
  logic              lovr;
  logic [STAT_W-1:0] set_vec;

  assign lda_go = lda_hit & ~pair_open;
  assign ldb_go = ldb_hit & pair_open;
  assign lovr   = (lda_go & ra_full & ~rd_ra) | (ldb_go & rb_full & ~rd_rb);

  always_comb begin
    set_vec          = '0;
    set_vec[ST_OVF]  = ovf_hit;
    set_vec[ST_LOVR] = lovr;
    set_vec[ST_RC]   = rc_hit;
    set_vec[ST_LDA]  = lda_go;
    set_vec[ST_LDB]  = ldb_go;
    set_vec[ST_TRG]  = trg_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra        <= '0;
      rb        <= '0;
      ra_full   <= 1'b0;
      rb_full   <= 1'b0;
      pair_open <= 1'b0;
      status    <= '0;
    end else begin
      if (lda_go) ra <= cnt;
      if (ldb_go) rb <= cnt;

      if (lda_go)     ra_full <= 1'b1;
      else if (rd_ra) ra_full <= 1'b0;
      if (ldb_go)     rb_full <= 1'b1;
      else if (rd_rb) rb_full <= 1'b0;

      if (lda_go)      pair_open <= 1'b1;
      else if (ldb_go) pair_open <= 1'b0;

      if (rd_stat) status <= set_vec;
      else         status <= status | set_vec;
    end
  end
endmodule

// File: rtl/cap_timer_chan.sv
module cap_timer_chan
  import cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_tick,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              cfg_wr,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [CNT_W-1:0]  cfg_rc,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic              cmd_trg,
  input  logic              rd_stat,
  input  logic              rd_ra,
  input  logic              rd_rb,
  output logic [CNT_W-1:0]  ra,
  output logic [CNT_W-1:0]  rb,
  output logic [CNT_W-1:0]  cnt,
  output logic [STAT_W-1:0] status
);
  localparam int NPIN = 2;

  mode_t            mode_q;
  logic [CNT_W-1:0] rc_q;
  logic [NPIN-1:0]  pins_raw;
  logic [NPIN-1:0]  p_rise;
  logic [NPIN-1:0]  p_fall;
  logic             trg_rise;
  logic             trg_fall;
  logic             trg_hit;
  logic             ext_restart;
  logic             lda_hit;
  logic             ldb_hit;
  logic             ldb_go;
  logic             pair_open;
  logic             clk_en_q;
  logic             cnt_run;
  logic             rc_hit;
  logic             ovf_hit;
  logic             rc_trg_en;
  logic             dis_on_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      rc_q   <= '1;
    end else if (cfg_wr) begin
      mode_q <= mode_t'(cfg_mode);
      rc_q   <= cfg_rc;
    end
  end

  assign pins_raw = {pin_b, pin_a};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    cap_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .pin  (pins_raw[g]),
      .rise (p_rise[g]),
      .fall (p_fall[g])
    );
  end

  assign trg_rise    = mode_q.trg_from_a ? p_rise[0] : p_rise[1];
  assign trg_fall    = mode_q.trg_from_a ? p_fall[0] : p_fall[1];
  assign trg_hit     = edge_match(mode_q.trg_edge, trg_rise, trg_fall);
  assign ext_restart = trg_hit | cmd_trg;
  assign lda_hit     = edge_match(mode_q.lda_edge, p_rise[0], p_fall[0]);
  assign ldb_hit     = edge_match(mode_q.ldb_edge, p_rise[0], p_fall[0]);
  assign rc_trg_en   = mode_q.rc_trg;
  assign dis_on_b    = mode_q.dis_on_b;

  cap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .tick        (cnt_tick),
    .cmd_en      (cmd_en),
    .cmd_dis     (cmd_dis),
    .ext_restart (ext_restart),
    .halt_req    (ldb_go & mode_q.stop_on_b),
    .dis_req     (ldb_go & dis_on_b),
    .rc_trg_en   (rc_trg_en),
    .rc_val      (rc_q),
    .cnt         (cnt),
    .clk_en      (clk_en_q),
    .run         (cnt_run),
    .rc_hit      (rc_hit),
    .ovf_hit     (ovf_hit)
  );

  cap_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt),
    .lda_hit   (lda_hit),
    .ldb_hit   (ldb_hit),
    .rd_ra     (rd_ra),
    .rd_rb     (rd_rb),
    .rd_stat   (rd_stat),
    .ovf_hit   (ovf_hit),
    .rc_hit    (rc_hit),
    .trg_hit   (trg_hit),
    .ra        (ra),
    .rb        (rb),
    .status    (status),
    .pair_open (pair_open),
    .ldb_go    (ldb_go)
  );
endmodule

// File: rtl/cap_timer_chan_chk.sv
module cap_timer_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             run,
  input logic             ext_restart,
  input logic             rc_trg_en,
  input logic [CNT_W-1:0] rc_val,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rb,
  input logic [7:0]       status,
  input logic             rd_stat,
  input logic             pair_open,
  input logic             ldb_go,
  input logic             dis_on_b,
  input logic             clk_en
);
  logic plain_step;
  assign plain_step = run && tick && !ext_restart && !(rc_trg_en && cnt == rc_val);

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    (plain_step && cnt != '1) |=> cnt == $past(cnt) + CNT_W'(1));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (plain_step && cnt == '1) |=> (cnt == '0 && status[0]));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!run && !ext_restart) |=> $stable(cnt));

  p_trig_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ext_restart |=> cnt == '0);

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_stat |=> ((status & $past(status)) == $past(status)));

  p_rb_order_r4: assert property (@(posedge clk) disable iff (rst)
    !pair_open |=> $stable(rb));

  p_dis_on_b_r9: assert property (@(posedge clk) disable iff (rst)
    (dis_on_b && ldb_go) |=> !clk_en);
endmodule

bind cap_timer_chan cap_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (cnt_tick),
  .run         (cnt_run),
  .ext_restart (ext_restart),
  .rc_trg_en   (rc_trg_en),
  .rc_val      (rc_q),
  .cnt         (cnt),
  .rb          (rb),
  .status      (status),
  .rd_stat     (rd_stat),
  .pair_open   (pair_open),
  .ldb_go      (ldb_go),
  .dis_on_b    (dis_on_b),
  .clk_en      (clk_en_q)
);

// File: tb/cap_timer_chan_tb.sv
`timescale 1ns/1ps
module cap_timer_chan_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_tick = 1'b0;
  logic         pin_a = 1'b0;
  logic         pin_b = 1'b0;
  logic         cfg_wr = 1'b0;
  logic [9:0]   cfg_mode = '0;
  logic [W-1:0] cfg_rc = '1;
  logic         cmd_en = 1'b0;
  logic         cmd_dis = 1'b0;
  logic         cmd_trg = 1'b0;
  logic         rd_stat = 1'b0;
  logic         rd_ra = 1'b0;
  logic         rd_rb = 1'b0;
  logic [W-1:0] ra, rb, cnt;
  logic [7:0]   status;

  int n_vec = 0;
  int n_bad = 0;

  cap_timer_chan #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .pin_a(pin_a), .pin_b(pin_b),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_rc(cfg_rc),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trg(cmd_trg),
    .rd_stat(rd_stat), .rd_ra(rd_ra), .rd_rb(rd_rb),
    .ra(ra), .rb(rb), .cnt(cnt), .status(status)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [9:0] mk(int lda, int ldb, int te, int ta, int rc, int stp, int dis);
    return {dis[0], stp[0], rc[0], ta[0], te[1:0], ldb[1:0], lda[1:0]};
  endfunction

  task automatic reset_dut();
    rst = 1'b1; cnt_tick = 0; pin_a = 0; pin_b = 0; cfg_wr = 0;
    cmd_en = 0; cmd_dis = 0; cmd_trg = 0; rd_stat = 0; rd_ra = 0; rd_rb = 0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic cfg(logic [9:0] m, logic [W-1:0] rcv);
    cfg_mode = m; cfg_rc = rcv; cfg_wr = 1'b1;
    cyc(1);
    cfg_wr = 1'b0;
  endtask

  task automatic en();
    cmd_en = 1'b1; cyc(1); cmd_en = 1'b0;
  endtask

  task automatic swtrg();
    cmd_trg = 1'b1; cyc(1); cmd_trg = 1'b0;
  endtask

  task automatic ticks(int n);
    cnt_tick = 1'b1; cyc(n); cnt_tick = 1'b0;
  endtask

  task automatic set_pin(bit use_a, logic v);
    if (use_a) pin_a = v; else pin_b = v;
    cyc(3);
  endtask

  task automatic read_all();
    rd_stat = 1'b1; rd_ra = 1'b1; rd_rb = 1'b1;
    cyc(1);
    rd_stat = 1'b0; rd_ra = 1'b0; rd_rb = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state and disabled clock
    reset_dut();
    chk("R1 cnt", cnt, 0);
    chk("R1 ra", ra, 0);
    chk("R1 rb", rb, 0);
    chk("R1 status", status, 0);
    ticks(5);
    chk("R1 disabled after reset", cnt, 0);

    // R3/R4 sweep of RA and RB edge selections
    for (int sa = 0; sa < 4; sa++) begin
      for (int sb = 0; sb < 4; sb++) begin
        int er, eb, la, lb;
        reset_dut();
        cfg(mk(sa, sb, 0, 0, 0, 0, 0), '1);
        en();
        ticks(5);
        set_pin(1, 1'b1);
        la = sa & 1; lb = 0;
        er = la ? 5 : 0; eb = 0;
        ticks(3);
        set_pin(1, 1'b0);
        if (la != 0) begin
          if ((sb & 2) != 0) begin eb = 8; lb = 1; end
        end else if ((sa & 2) != 0) begin
          er = 8; la = 1;
        end
        chk("R3 ra sweep", ra, er);
        chk("R4 rb sweep", rb, eb);
        chk("R3 R4 status sweep", status, (lb << 6) | (la << 5));
        chk("R2 count sweep", cnt, 8);
      end
    end

    // R3 timestamp spacing with continuous ticking
    reset_dut();
    cfg(mk(1, 2, 0, 0, 0, 0, 0), '1);
    en();
    cnt_tick = 1'b1;
    pin_a = 1'b1;
    cyc(37);
    pin_a = 1'b0;
    cyc(4);
    cnt_tick = 1'b0;
    chk("R3 ra detect-cycle value", ra, 2);
    chk("R3 rb-ra spacing", rb - ra, 37);

    // R5 load overrun
    reset_dut();
    cfg(mk(3, 3, 0, 0, 0, 0, 0), '1);
    en();
    ticks(1); set_pin(1, 1'b1);
    ticks(1); set_pin(1, 1'b0);
    ticks(1); set_pin(1, 1'b1);
    chk("R5 ra reload value", ra, 3);
    chk("R5 overrun on unread RA", status, 8'h62);
    read_all();
    chk("R10 status read clears", status, 0);
    ticks(1); set_pin(1, 1'b0);
    chk("R5 no overrun after RB read", status, 8'h40);
    chk("R4 rb value", rb, 4);
    ticks(1); set_pin(1, 1'b1);
    chk("R5 no overrun after RA read", status, 8'h60);
    ticks(1); set_pin(1, 1'b0);
    chk("R5 overrun on unread RB", status, 8'h62);

    // R6 trigger edge and source sweep
    for (int te = 0; te < 4; te++) begin
      for (int src = 0; src < 2; src++) begin
        int ec;
        reset_dut();
        cfg(mk(0, 0, te, src, 0, 0, 0), '1);
        en();
        ticks(20);
        set_pin(src == 0, 1'b1);
        set_pin(src == 0, 1'b0);
        chk("R6 other pin ignored", cnt, 20);
        chk("R6 other pin no status", status, 0);
        set_pin(src != 0, 1'b1);
        ec = ((te & 1) != 0) ? 0 : 20;
        chk("R6 rising trigger", cnt, ec);
        ticks(4);
        ec += 4;
        set_pin(src != 0, 1'b0);
        if ((te & 2) != 0) ec = 0;
        chk("R6 falling trigger", cnt, ec);
        chk("R6 trigger status", status, (te != 0) ? 8'h80 : 8'h00);
      end
    end

    // R6 same-cycle capture and trigger on one edge of A
    reset_dut();
    cfg(mk(1, 0, 1, 1, 0, 0, 0), '1);
    en();
    ticks(30);
    set_pin(1, 1'b1);
    chk("R6 capture before reset", ra, 30);
    chk("R6 counter zeroed", cnt, 0);
    chk("R6 both flags", status, 8'hA0);

    // R7 RC compare with and without restart
    reset_dut();
    cfg(mk(0, 0, 0, 0, 1, 0, 0), 16'd9);
    en();
    ticks(25);
    chk("R7 rc restart count", cnt, 5);
    chk("R7 rc status", status, 8'h10);
    reset_dut();
    cfg(mk(0, 0, 0, 0, 0, 0, 0), 16'd9);
    en();
    ticks(12);
    chk("R7 rc no restart count", cnt, 12);
    chk("R7 rc status no restart", status, 8'h10);

    // R2 wrap
    reset_dut();
    cfg(mk(0, 0, 0, 0, 0, 0, 0), 16'd100);
    en();
    ticks(65535);
    chk("R2 at max", cnt, 16'hFFFF);
    ticks(1);
    chk("R2 wrap to zero", cnt, 0);
    chk("R2 wrap flag", status, 8'h11);

    // R8 stop on RB load
    reset_dut();
    cfg(mk(1, 2, 0, 0, 0, 1, 0), '1);
    en();
    ticks(3); set_pin(1, 1'b1);
    ticks(4); set_pin(1, 1'b0);
    chk("R8 rb value", rb, 7);
    ticks(6);
    chk("R8 halted", cnt, 7);
    swtrg();
    chk("R8 restart zero", cnt, 0);
    ticks(5);
    chk("R8 resumed", cnt, 5);
    chk("R11 sw trigger no flag", status, 8'h60);

    // R9 disable on RB load
    reset_dut();
    cfg(mk(1, 2, 0, 0, 0, 0, 1), '1);
    en();
    ticks(3); set_pin(1, 1'b1);
    ticks(4); set_pin(1, 1'b0);
    ticks(6);
    chk("R9 disabled", cnt, 7);
    swtrg();
    ticks(5);
    chk("R9 trigger zeroes but stays off", cnt, 0);
    en();
    ticks(5);
    chk("R9 re-enabled", cnt, 5);

    // R10 read coinciding with a new event
    reset_dut();
    cfg(mk(1, 0, 1, 0, 0, 0, 0), '1);
    en();
    ticks(10);
    set_pin(0, 1'b1);
    chk("R10 trigger flag present", status, 8'h80);
    pin_a = 1'b1;
    cyc(2);
    rd_stat = 1'b1;
    cyc(1);
    rd_stat = 1'b0;
    chk("R10 read keeps same-cycle event", status, 8'h20);
    rd_stat = 1'b1; cyc(1); rd_stat = 1'b0;
    chk("R10 cleared", status, 0);

    // R11 command priority
    reset_dut();
    cfg(mk(0, 0, 0, 0, 0, 0, 0), '1);
    en();
    ticks(4);
    cmd_en = 1'b1; cmd_dis = 1'b1;
    cyc(1);
    cmd_en = 1'b0; cmd_dis = 1'b0;
    ticks(3);
    chk("R11 disable wins", cnt, 4);
    en();
    ticks(2);
    chk("R11 enable resumes", cnt, 6);
    swtrg();
    chk("R11 sw trigger zero", cnt, 0);
    chk("R11 sw trigger status", status, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule